// File: doc/BRIEF.md
# Line-Range and Brown-Out Monitor

This block sits beside a quasi-resonant flyback controller. It turns two digital comparator results taken from the rectified-input sense node into two qualified status flags. The first flag, `high_line_o`, tells valley selection whether the mains is in the high range. The second flag, `bo_nok_o`, tells the fault manager that the input is too low to run. Each comparator has two reference levels. The block drives a level-select output for each comparator from the present state of the matching flag, so the analog side gets hysteresis without any analog state of its own.

Both comparator inputs pass through a synchronizer of `SYNC_STAGES` flops. Each flag is then run by its own state machine, and the two machines differ in how they qualify changes.

The line-range machine treats both directions alike. It has four states: `LR_LOW`, `LR_RISE`, `LR_HIGH` and `LR_FALL`. A qualifying sample moves it `LR_LOW`→`LR_RISE` or `LR_HIGH`→`LR_FALL`, which starts a count of one. The machine moves on to the opposite stable state after `LINE_BLANK_CYC` consecutive qualifying samples; this is the *commit* transition. A single non-qualifying sample sends it back to its stable state and drops the count; this is the *abort* transition.

The brown-out machine is asymmetric. It has three states: `BO_FAULT`, `BO_GOOD` and `BO_SAG`.
- From `BO_FAULT`, one sample above the upper level goes straight to `BO_GOOD`; this is the *fast clear*.
- A low sample moves `BO_GOOD`→`BO_SAG`.
- `BO_SAG` returns to `BO_GOOD` on any high sample; this is the *recover* transition.
- `BO_SAG` commits to `BO_FAULT` after `BO_BLANK_CYC` consecutive low samples.

Every flag change comes with a one-cycle change pulse.

Top module: `lrbo_monitor`

## Requirements
- R1: After reset `high_line_o`=0 (low line) and `bo_nok_o`=1 (brown-out asserted). Both level selects equal their flags, and both change pulses are 0.
- R2: While low line, `high_line_o` sets at the clock edge that consumes the `LINE_BLANK_CYC`-th consecutive synchronized `line_above_i`=1 sample.
- R3: While high line, `high_line_o` clears at the clock edge that consumes the `LINE_BLANK_CYC`-th consecutive synchronized `line_above_i`=0 sample.
- R4: A line excursion shorter than `LINE_BLANK_CYC` samples leaves `high_line_o` unchanged, and the qualification count restarts from zero.
- R5: While brown-out is asserted, the first synchronized `bo_above_i`=1 sample clears `bo_nok_o` at the edge that consumes it, with no blanking.
- R6: While brown-out is clear, `bo_nok_o` sets only after `BO_BLANK_CYC` consecutive synchronized `bo_above_i`=0 samples. A shorter dip is ignored and restarts the count.
- R7: `line_lvl_sel_o` equals `high_line_o`, where 1 selects the lower (falling) line level. `bo_lvl_sel_o` equals `bo_nok_o`, where 1 selects the upper (start) brown-out level.
- R8: `line_chg_o` and `bo_chg_o` are high for exactly the one cycle in which the matching flag has just changed, and low at all other times.
- R9: An input sample is first acted on `SYNC_STAGES` clock edges after it is captured. A change driven before edge k therefore reaches a flag no earlier than edge k+`SYNC_STAGES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_above_i | input | 1 | Line comparator: sense node above the selected line level |
| bo_above_i | input | 1 | Brown-out comparator: sense node above the selected brown-out level |
| line_lvl_sel_o | output | 1 | Line level select (1 = lower level) |
| bo_lvl_sel_o | output | 1 | Brown-out level select (1 = upper level) |
| high_line_o | output | 1 | Qualified high-line flag |
| bo_nok_o | output | 1 | Qualified brown-out flag (1 = input too low) |
| line_chg_o | output | 1 | One-cycle pulse on a line-range change |
| bo_chg_o | output | 1 | One-cycle pulse on a brown-out change |

## Verification
The embedded properties assume that the comparator inputs hold for a full clock once they reach the synchronizer's last stage. They also assume that each comparator's meaning follows the level the block last selected.

The bench honours both assumptions. It changes a modelled sense voltage only on falling clock edges. It derives each comparator bit from that voltage and from the level select the design is currently driving, so every high-to-low boundary crossing and every in-band hold behaves as the real analog loop would. The scenarios include dips and spikes just shorter than each blanking window, holds inside each hysteresis band, and rapid toggling.

// File: rtl/lrbo_pkg.sv
package lrbo_pkg;

    typedef enum logic [1:0] {
        LR_LOW  = 2'd0,
        LR_RISE = 2'd1,
        LR_HIGH = 2'd2,
        LR_FALL = 2'd3
    } lr_state_t;

    typedef enum logic [1:0] {
        BO_FAULT = 2'd0,
        BO_GOOD  = 2'd1,
        BO_SAG   = 2'd2
    } bo_state_t;

endpackage

// File: rtl/lrbo_sync.sv
module lrbo_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign q_o = d_i;
        end else begin : g_chain
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= {STAGES{RST_VAL}};
                end else if (STAGES == 1) begin
                    chain <= d_i;
                end else begin
                    chain <= {chain[STAGES-2:0], d_i};
                end
            end
            assign q_o = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/lrbo_line_fsm.sv
module lrbo_line_fsm
    import lrbo_pkg::*;
#(
    parameter int BLANK = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic above_i,
    output logic high_line_o,
    output logic lvl_sel_o,
    output logic chg_o
);

    localparam int CW = (BLANK < 2) ? 1 : $clog2(BLANK + 1);
    localparam logic [CW-1:0] LAST = CW'(BLANK - 1);
    localparam bit INSTANT = (BLANK <= 1);

    lr_state_t     state, state_nxt;
    logic [CW-1:0] cnt, cnt_nxt;
    logic          chg_q, chg_nxt;

    // next-state and qualification count
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        chg_nxt   = 1'b0;
        unique case (state)
            LR_LOW: begin
                if (above_i) begin
                    state_nxt = INSTANT ? LR_HIGH : LR_RISE;
                    cnt_nxt   = INSTANT ? '0 : CW'(1);
                    chg_nxt   = INSTANT;
                end
            end
            LR_RISE: begin
                if (!above_i) begin
                    state_nxt = LR_LOW;
                    cnt_nxt   = '0;
                end else if (cnt == LAST) begin
                    state_nxt = LR_HIGH;
                    cnt_nxt   = '0;
                    chg_nxt   = 1'b1;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            LR_HIGH: begin
                if (!above_i) begin
                    state_nxt = INSTANT ? LR_LOW : LR_FALL;
                    cnt_nxt   = INSTANT ? '0 : CW'(1);
                    chg_nxt   = INSTANT;
                end
            end
            LR_FALL: begin
                if (above_i) begin
                    state_nxt = LR_HIGH;
                    cnt_nxt   = '0;
                end else if (cnt == LAST) begin
                    state_nxt = LR_LOW;
                    cnt_nxt   = '0;
                    chg_nxt   = 1'b1;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            default: begin
                state_nxt = LR_LOW;
                cnt_nxt   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= LR_LOW;
            cnt   <= '0;
            chg_q <= 1'b0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
            chg_q <= chg_nxt;
        end
    end

    // outputs
    always_comb begin
        high_line_o = (state == LR_HIGH) || (state == LR_FALL);
        lvl_sel_o   = high_line_o;
        chg_o       = chg_q;
    end

    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    assert_hold_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!high_line_o && !above_i) |=> !high_line_o);

    assert_hold_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (high_line_o && above_i) |=> high_line_o);

    assert_change_pulsed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (high_line_o != $past(high_line_o)) |-> chg_o);

    assert_pulse_only_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
        chg_o |-> (high_line_o != $past(high_line_o)));

endmodule

// File: rtl/lrbo_bo_fsm.sv
module lrbo_bo_fsm
    import lrbo_pkg::*;
#(
    parameter int BLANK = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic above_i,
    output logic bo_nok_o,
    output logic lvl_sel_o,
    output logic chg_o
);

    localparam int CW = (BLANK < 2) ? 1 : $clog2(BLANK + 1);
    localparam logic [CW-1:0] LAST = CW'(BLANK - 1);
    localparam bit INSTANT = (BLANK <= 1);

    bo_state_t     state, state_nxt;
    logic [CW-1:0] cnt, cnt_nxt;
    logic          chg_q, chg_nxt;

    // next-state: fast clear, blanked assertion
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        chg_nxt   = 1'b0;
        unique case (state)
            BO_FAULT: begin
                if (above_i) begin
                    state_nxt = BO_GOOD;
                    cnt_nxt   = '0;
                    chg_nxt   = 1'b1;
                end
            end
            BO_GOOD: begin
                if (!above_i) begin
                    state_nxt = INSTANT ? BO_FAULT : BO_SAG;
                    cnt_nxt   = INSTANT ? '0 : CW'(1);
                    chg_nxt   = INSTANT;
                end
            end
            BO_SAG: begin
                if (above_i) begin
                    state_nxt = BO_GOOD;
                    cnt_nxt   = '0;
                end else if (cnt == LAST) begin
                    state_nxt = BO_FAULT;
                    cnt_nxt   = '0;
                    chg_nxt   = 1'b1;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            default: begin
                state_nxt = BO_FAULT;
                cnt_nxt   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= BO_FAULT;
            cnt   <= '0;
            chg_q <= 1'b0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
            chg_q <= chg_nxt;
        end
    end

    // outputs
    always_comb begin
        bo_nok_o  = (state == BO_FAULT);
        lvl_sel_o = bo_nok_o;
        chg_o     = chg_q;
    end

    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    assert_fast_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bo_nok_o && above_i) |=> !bo_nok_o);

    assert_hold_good_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!bo_nok_o && above_i) |=> !bo_nok_o);

    assert_change_pulsed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bo_nok_o != $past(bo_nok_o)) |-> chg_o);

    assert_pulse_only_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
        chg_o |-> (bo_nok_o != $past(bo_nok_o)));

endmodule

// File: rtl/lrbo_monitor.sv
module lrbo_monitor #(
    parameter int SYNC_STAGES    = 2,
    parameter int LINE_BLANK_CYC = 1_250_000,
    parameter int BO_BLANK_CYC   = 2_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_above_i,
    input  logic bo_above_i,
    output logic line_lvl_sel_o,
    output logic bo_lvl_sel_o,
    output logic high_line_o,
    output logic bo_nok_o,
    output logic line_chg_o,
    output logic bo_chg_o
);

    logic line_s;
    logic bo_s;

    lrbo_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_line_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (line_above_i),
        .q_o   (line_s)
    );

    lrbo_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_bo_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (bo_above_i),
        .q_o   (bo_s)
    );

    lrbo_line_fsm #(.BLANK(LINE_BLANK_CYC)) u_line (
        .clk         (clk),
        .rst_n       (rst_n),
        .above_i     (line_s),
        .high_line_o (high_line_o),
        .lvl_sel_o   (line_lvl_sel_o),
        .chg_o       (line_chg_o)
    );

    lrbo_bo_fsm #(.BLANK(BO_BLANK_CYC)) u_bo (
        .clk       (clk),
        .rst_n     (rst_n),
        .above_i   (bo_s),
        .bo_nok_o  (bo_nok_o),
        .lvl_sel_o (bo_lvl_sel_o),
        .chg_o     (bo_chg_o)
    );

endmodule

// File: tb/tb_lrbo_monitor.sv
module tb_lrbo_monitor;

    localparam int SYNC = 2;
    localparam int LN   = 16;
    localparam int BN   = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   v_mv = 500;

    logic line_lvl_sel, bo_lvl_sel, high_line, bo_nok, line_chg, bo_chg;
    logic line_above, bo_above;

    always #10 clk = ~clk;

    // analog comparator model driven by the design's level selects
    assign line_above = (v_mv > (line_lvl_sel ? 2300 : 2400));
    assign bo_above   = (v_mv > (bo_lvl_sel ? 1000 : 900));

    lrbo_monitor #(
        .SYNC_STAGES(SYNC), .LINE_BLANK_CYC(LN), .BO_BLANK_CYC(BN)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .line_above_i(line_above), .bo_above_i(bo_above),
        .line_lvl_sel_o(line_lvl_sel), .bo_lvl_sel_o(bo_lvl_sel),
        .high_line_o(high_line), .bo_nok_o(bo_nok),
        .line_chg_o(line_chg), .bo_chg_o(bo_chg)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;
    bit started = 0;

    // behavioural reference model
    bit lq[$];
    bit bq[$];
    bit m_hl = 0, m_bo = 1, m_hp = 0, m_bp = 0;
    int m_lc = 0, m_bc = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            lq.delete(); bq.delete();
            for (int i = 0; i < SYNC; i++) begin lq.push_back(0); bq.push_back(0); end
            m_hl = 0; m_bo = 1; m_hp = 0; m_bp = 0; m_lc = 0; m_bc = 0;
        end else begin
            bit sl, sb;
            sl = lq.pop_front(); lq.push_back(line_above);
            sb = bq.pop_front(); bq.push_back(bo_above);
            m_hp = 0; m_bp = 0;
            if (sl != m_hl) begin
                m_lc++;
                if (m_lc >= LN) begin m_hl = sl; m_hp = 1; m_lc = 0; end
            end else m_lc = 0;
            if (m_bo) begin
                if (sb) begin m_bo = 0; m_bp = 1; m_bc = 0; end
            end else if (!sb) begin
                m_bc++;
                if (m_bc >= BN) begin m_bo = 1; m_bp = 1; m_bc = 0; end
            end else m_bc = 0;
        end
        started = 1;
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            chk("R2 R3 R4 high_line", high_line, m_hl);
            chk("R5 R6 bo_nok", bo_nok, m_bo);
            chk("R7 line_lvl_sel", line_lvl_sel, m_hl);
            chk("R7 bo_lvl_sel", bo_lvl_sel, m_bo);
            chk("R8 line_chg", line_chg, m_hp);
            chk("R8 bo_chg", bo_chg, m_bp);
        end
    end

    task automatic hold(input int mv, input int n);
        v_mv = mv;
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        v_mv = 500;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        hold(500, 3);
        // R1: reset state
        chk("R1 high_line", high_line, 1'b0);
        chk("R1 bo_nok", bo_nok, 1'b1);
        chk("R1 line_lvl_sel", line_lvl_sel, 1'b0);
        chk("R1 bo_lvl_sel", bo_lvl_sel, 1'b1);
        chk("R1 pulses", line_chg | bo_chg, 1'b0);

        // R9 latency then R5 fast clear
        hold(1200, SYNC);
        chk("R9 bo_nok before sync latency", bo_nok, 1'b1);
        @(negedge clk);
        chk("R5 bo_nok cleared", bo_nok, 1'b0);
        chk("R8 bo_chg pulse", bo_chg, 1'b1);
        @(negedge clk);
        chk("R8 bo_chg one cycle", bo_chg, 1'b0);

        // R6/R7: in-band hold, short dip, long dip
        hold(950, 30);
        chk("R6 in band stays clear", bo_nok, 1'b0);
        hold(850, BN - 4);
        hold(950, 10);
        chk("R6 short dip ignored", bo_nok, 1'b0);
        hold(850, BN + SYNC + 2);
        chk("R6 long dip asserts", bo_nok, 1'b1);
        chk("R7 upper brown-out level", bo_lvl_sel, 1'b1);
        hold(950, 20);
        chk("R7 band after assert stays", bo_nok, 1'b1);
        hold(1100, 10);
        chk("R5 clears again", bo_nok, 1'b0);

        // line range
        hold(2450, LN - 3);
        hold(2350, 10);
        chk("R4 short rise ignored", high_line, 1'b0);
        for (int i = 0; i < 6; i++) begin
            hold(2450, 3);
            hold(2000, 3);
        end
        chk("R4 toggling ignored", high_line, 1'b0);
        hold(2450, LN + SYNC + 1);
        chk("R2 high line set", high_line, 1'b1);
        chk("R7 lower line level", line_lvl_sel, 1'b1);
        hold(2350, 40);
        chk("R3 band keeps high", high_line, 1'b1);
        hold(2250, LN - 2);
        hold(2350, 10);
        chk("R4 short fall ignored", high_line, 1'b1);
        hold(2250, LN + SYNC + 1);
        chk("R3 low line restored", high_line, 1'b0);
        hold(500, BN + SYNC + 4);
        chk("R6 final brown-out", bo_nok, 1'b1);
        chk("R3 line stays low", high_line, 1'b0);

        finish_run();
    end

endmodule